// File: doc/BRIEF.md
# Reaction Timing Game Controller

This block runs a one-player timing game. It takes two single-cycle button pulses, start and stop, and a tick-enable that sets the game's pace. A start press in the idle state clears the score and begins play. While play runs, a row of LEDs fills from the right, one LED per step, and a four-digit decimal score counts up once per tick. The player must press stop while every LED is lit. A hit blinks the LEDs and keeps the score on show. A miss empties the LEDs one at a time and clears the score. After either sequence the block returns to idle by itself.

Button debouncing and seven-segment multiplexing are left to neighbouring blocks. The score leaves the block as packed BCD for a display driver. A two-bit phase output shows which part of the game is running.

Top module: `reaction_game`

## Requirements
- R1: A synchronous active-high `rst` forces the idle phase, all LEDs off and the score to zero on the next clock edge.
- R2: A `start_i` pulse in idle enters play on that edge with only `leds[0]` (the rightmost LED) lit and the score at zero. A `start_i` pulse in any other phase changes nothing.
- R3: In play, each step of `STEP_TICKS` tick pulses lights one more LED, directly left of the lit run. The lit LEDs always form a contiguous run that starts at bit 0.
- R4: In play, the score goes up by one on every tick pulse. It is packed BCD, with the least significant digit in bits 3:0. It stays at 9999 once it gets there.
- R5: A stop press in play while all `NUM_LEDS` LEDs are lit is a hit. It enters the win phase on that edge with the score frozen at its value before the press.
- R6: A stop press in play while any LED is still dark is a miss. It enters the lose phase on that edge with the score set to zero and the LEDs unchanged.
- R7: The all-lit window lasts exactly one step. If no stop press arrives before that step ends, the block enters the lose phase with all LEDs lit and the score at zero.
- R8: In the win phase, all LEDs invert every `BLINK_STEPS` steps. On the 2*`BLINK_PERIODS`-th inversion point the block goes to idle with the LEDs off and the score kept.
- R9: In the lose phase, each step turns off the leftmost lit LED. The step that would turn off the last LED moves the block to idle with all LEDs off. In idle the LEDs are always off.
- R10: A `stop_i` pulse outside play changes nothing. Cycles without a tick pulse leave the score and LEDs unchanged in play.
- R11: `state_o` encodes idle as 0, play as 1, win as 2 and lose as 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timing enable, one pulse per game tick |
| start_i | input | 1 | Debounced start button pulse |
| stop_i | input | 1 | Debounced stop button pulse |
| leds | output | NUM_LEDS | LED row, bit 0 rightmost |
| score | output | 4*DIGITS | Packed BCD score |
| state_o | output | 2 | Game phase: 0 idle, 1 play, 2 win, 3 lose |

## Verification
A wrong tick-within-step count shows up at the LED row within one step: an LED appears early or late, a blink arrives at the wrong time, or a drain runs too long. Each of these shows on the very next sample. A bad hit decision shows on `state_o` on the edge after the stop press. So the sweep presses stop after every possible tick count of a round, which covers both edges of the all-lit window and the timeout. A fault in the BCD carry or in saturation shows in the score on the first tick that crosses a digit boundary or reaches 9999.

// File: rtl/reaction_game.sv
module reaction_game #(
  parameter int NUM_LEDS      = 16,
  parameter int STEP_TICKS    = 4,
  parameter int BLINK_STEPS   = 8,
  parameter int BLINK_PERIODS = 4,
  parameter int DIGITS        = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  start_i,
  input  logic                  stop_i,
  output logic [NUM_LEDS-1:0]   leds,
  output logic [4*DIGITS-1:0]   score,
  output logic [1:0]            state_o
);
  localparam int TW = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
  localparam int BW = (BLINK_STEPS > 1) ? $clog2(BLINK_STEPS) : 1;
  localparam int GW = (2*BLINK_PERIODS > 1) ? $clog2(2*BLINK_PERIODS) : 1;

  typedef enum logic [1:0] {IDLE = 2'd0, PLAY = 2'd1, WIN = 2'd2, LOSE = 2'd3} phase_t;
  phase_t state;

  logic [TW-1:0] tcnt;
  logic [BW-1:0] scnt;
  logic [GW-1:0] tog;
  logic [4*DIGITS-1:0] score_inc;
  logic sat;

  wire step       = tick && (tcnt == TW'(STEP_TICKS-1));
  wire full       = &leds;
  wire last_blink = (scnt == BW'(BLINK_STEPS-1));
  wire last_tog   = (tog == GW'(2*BLINK_PERIODS-1));
  wire last_led   = (leds[NUM_LEDS-1:1] == '0);

  assign state_o = state;

  always_comb begin
    logic carry;
    score_inc = score;
    carry = 1'b1;
    sat = 1'b1;
    for (int d = 0; d < DIGITS; d++) begin
      if (score[4*d +: 4] != 4'd9) sat = 1'b0;
      if (carry) begin
        if (score[4*d +: 4] == 4'd9) score_inc[4*d +: 4] = 4'd0;
        else begin
          score_inc[4*d +: 4] = score[4*d +: 4] + 4'd1;
          carry = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= IDLE;
      leds  <= '0;
      score <= '0;
      tcnt  <= '0;
      scnt  <= '0;
      tog   <= '0;
    end else begin
      case (state)
        IDLE: if (start_i) begin
          state <= PLAY;
          leds  <= NUM_LEDS'(1);
          score <= '0;
          tcnt  <= '0;
        end
        PLAY: begin
          if (stop_i) begin
            tcnt <= '0;
            scnt <= '0;
            tog  <= '0;
            if (full) state <= WIN;
            else begin
              state <= LOSE;
              score <= '0;
            end
          end else if (tick) begin
            if (!sat) score <= score_inc;
            if (step) begin
              tcnt <= '0;
              if (full) begin
                state <= LOSE;
                score <= '0;
              end else leds <= {leds[NUM_LEDS-2:0], 1'b1};
            end else tcnt <= tcnt + 1'b1;
          end
        end
        WIN: if (tick) begin
          if (step) begin
            tcnt <= '0;
            if (last_blink) begin
              scnt <= '0;
              tog  <= tog + 1'b1;
              if (last_tog) begin
                state <= IDLE;
                leds  <= '0;
              end else leds <= ~leds;
            end else scnt <= scnt + 1'b1;
          end else tcnt <= tcnt + 1'b1;
        end
        LOSE: if (tick) begin
          if (step) begin
            tcnt <= '0;
            if (last_led) begin
              state <= IDLE;
              leds  <= '0;
            end else leds <= leds >> 1;
          end else tcnt <= tcnt + 1'b1;
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/game_checker.sv
module game_checker #(
  parameter int NUM_LEDS = 16,
  parameter int DIGITS   = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                tick,
  input logic                start_i,
  input logic                stop_i,
  input logic [NUM_LEDS-1:0] leds,
  input logic [4*DIGITS-1:0] score,
  input logic [1:0]          state_o
);
  logic digits_ok;
  always_comb begin
    digits_ok = 1'b1;
    for (int d = 0; d < DIGITS; d++)
      if (score[4*d +: 4] > 4'd9) digits_ok = 1'b0;
  end

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (state_o == 2'd0 && leds == '0 && score == '0)); // R1
  AST_START_ENTRY: assert property (@(posedge clk) disable iff (rst) (state_o == 2'd0 && start_i) |=> (state_o == 2'd1 && leds == NUM_LEDS'(1) && score == '0)); // R2
  AST_FILL_SHAPE: assert property (@(posedge clk) disable iff (rst) (state_o == 2'd1) |-> (leds[0] && ((leds & (leds + 1'b1)) == '0))); // R3
  AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (rst) digits_ok); // R4
  AST_HIT_ONLY_FULL: assert property (@(posedge clk) disable iff (rst) (state_o == 2'd1 && stop_i && (&leds)) |=> (state_o == 2'd2)); // R5
  AST_WIN_FROZEN: assert property (@(posedge clk) disable iff (rst) (state_o == 2'd2 && $past(state_o) == 2'd2) |-> $stable(score)); // R5
  AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (rst) (state_o == 2'd3) |-> (score == '0)); // R6
  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (rst) (state_o == 2'd0) |-> (leds == '0)); // R9
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst) (state_o == 2'd0 && !start_i) |=> (state_o == 2'd0 && $stable(score))); // R10
  AST_NO_TICK: assert property (@(posedge clk) disable iff (rst) (state_o == 2'd1 && !tick && !stop_i) |=> (state_o == 2'd1 && $stable(leds) && $stable(score))); // R10
endmodule

bind reaction_game game_checker #(.NUM_LEDS(NUM_LEDS), .DIGITS(DIGITS)) u_chk (.*);

// File: tb/tb_reaction_game.sv
`timescale 1ns/1ps
module tb_reaction_game;
  localparam int N = 16, S = 4, BS = 8, BP = 4, SAT_S = 700;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b1;
  logic start_i = 1'b0, stop_i = 1'b0, start2 = 1'b0, stop2 = 1'b0;
  logic [N-1:0] leds, leds2;
  logic [15:0] score, score2;
  logic [1:0] st, st2;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  reaction_game #(.NUM_LEDS(N), .STEP_TICKS(S), .BLINK_STEPS(BS), .BLINK_PERIODS(BP), .DIGITS(4)) dut (
    .clk(clk), .rst(rst), .tick(tick), .start_i(start_i), .stop_i(stop_i),
    .leds(leds), .score(score), .state_o(st));

  reaction_game #(.NUM_LEDS(N), .STEP_TICKS(SAT_S), .BLINK_STEPS(BS), .BLINK_PERIODS(BP), .DIGITS(4)) dut_sat (
    .clk(clk), .rst(rst), .tick(tick), .start_i(start2), .stop_i(stop2),
    .leds(leds2), .score(score2), .state_o(st2));

  function automatic logic [15:0] bcd(int v);
    int x = (v > 9999) ? 9999 : v;
    return {4'(x / 1000), 4'((x / 100) % 10), 4'((x / 10) % 10), 4'(x % 10)};
  endfunction

  function automatic logic [N-1:0] ones(int n);
    logic [N-1:0] r = '0;
    for (int i = 0; i < n && i < N; i++) r[i] = 1'b1;
    return r;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic play_round(int k, bit timeout);
    int n;
    bit hit;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2", "entry state", st, 1);
    chk("R2", "entry leds", leds, 1);
    chk("R2", "entry score", score, 0);
    if (timeout) begin
      wait_cyc(16*S - 1);
      chk("R7", "last play state", st, 1);
      chk("R7", "last play leds", leds, ones(N));
      wait_cyc(1);
      chk("R7", "timeout state", st, 3);
      chk("R7", "timeout leds", leds, ones(N));
      chk("R7", "timeout score", score, 0);
      n = N;
      hit = 1'b0;
    end else begin
      wait_cyc(k);
      n = 1 + k / S;
      chk("R3", "fill leds", leds, ones(n));
      chk("R4", "play score", score, bcd(k));
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      hit = (n == N);
      if (hit) begin
        chk("R5", "hit state", st, 2);
        chk("R5", "hit score", score, bcd(k));
      end else begin
        chk("R6", "miss state", st, 3);
        chk("R6", "miss score", score, 0);
        chk("R6", "miss leds", leds, ones(n));
      end
    end
    if (hit) begin
      for (int m = 1; m < 2*BP; m++) begin
        wait_cyc(BS*S);
        chk("R8", "blink leds", leds, (m % 2) ? '0 : ones(N));
        chk("R8", "blink score", score, bcd(k));
      end
      wait_cyc(BS*S);
      chk("R8", "win end state", st, 0);
      chk("R8", "win end leds", leds, 0);
      chk("R8", "win end score", score, bcd(k));
    end else begin
      for (int j = 1; j < n; j++) begin
        wait_cyc(S);
        chk("R9", "drain leds", leds, ones(n - j));
      end
      wait_cyc(S);
      chk("R9", "lose end state", st, 0);
      chk("R9", "lose end leds", leds, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, all requirements at risk");
    finish_run;
  end

  initial begin
    wait_cyc(3);
    chk("R1", "reset leds", leds, 0);
    chk("R1", "reset score", score, 0);
    chk("R11", "reset state code idle", st, 0);
    rst = 1'b0;
    wait_cyc(1);

    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk("R10", "stop in idle state", st, 0);
    chk("R10", "stop in idle leds", leds, 0);

    for (int k = 0; k < 16*S; k++) play_round(k, 1'b0);

    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk("R10", "stop in idle keeps score", score, bcd(16*S - 1));
    chk("R10", "stop in idle keeps state", st, 0);

    play_round(0, 1'b1);

    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_cyc(5);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2", "start in play ignored score", score, bcd(6));
    chk("R2", "start in play ignored leds", leds, ones(1 + 6 / S));
    chk("R11", "play state code", st, 1);
    tick = 1'b0;
    wait_cyc(10);
    chk("R10", "no tick score", score, bcd(6));
    chk("R10", "no tick leds", leds, ones(1 + 6 / S));
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk("R6", "miss without tick", st, 3);
    chk("R11", "lose state code", st, 3);
    tick = 1'b1;
    wait_cyc(2*S);
    chk("R9", "two-led drain done", st, 0);

    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_cyc(20);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "mid-play reset state", st, 0);
    chk("R1", "mid-play reset leds", leds, 0);
    chk("R1", "mid-play reset score", score, 0);

    start2 = 1'b1;
    @(negedge clk);
    start2 = 1'b0;
    wait_cyc(9999);
    chk("R4", "score reaches 9999", score2, 16'h9999);
    wait_cyc(50);
    chk("R4", "score saturates", score2, 16'h9999);
    chk("R4", "still in play", st2, 1);
    stop2 = 1'b1;
    @(negedge clk);
    stop2 = 1'b0;
    chk("R6", "late-round miss", st2, 3);
    chk("R6", "late-round score", score2, 0);
    wait_cyc((1 + 10049 / SAT_S) * SAT_S);
    chk("R9", "long drain ends", st2, 0);
    chk("R9", "long drain leds", leds2, 0);

    finish_run;
  end
endmodule